// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Selectable Write Policy

This block is a clocked single-port memory of `DEPTH` words. Each word holds `DATA_W` data bits and `PAR_W` side bits. The side bits are usually parity, and they are stored and returned with the data. Every access is sampled on the rising clock edge, and read data comes out through a registered output one cycle later. A parameter picks what the output register shows in a cycle that writes. It can show the word being written, the word that was overwritten, or it can keep the value it already had.

The output register has two separate constants:
- `INIT_OUT` is loaded while the asynchronous reset is asserted, so it is the power-up value.
- `SRVAL` is loaded by the synchronous set/reset input.

The memory array is loaded from the parameter `INIT_IMAGE` whenever the asynchronous reset is asserted. Word `i` sits at bits `[i*W +: W]` of that image, so address 0 is at the rightmost end, and `W = DATA_W + PAR_W`. Within a word, the data is in the low `DATA_W` bits and the side bits are above it.

The asynchronous reset is released through a two-stage synchronizer. The block therefore starts to operate on the third rising edge after `rst_n` goes high.

Top module: `sram_wmode`

## Requirements
- R1: While `en` is low, a rising edge changes neither the memory nor the output, whatever `we`, `ssr`, `addr` and the data inputs are.
- R2: With `en` high and `we` and `ssr` low, the word at `addr` appears on `{doutp, dout}` after the next rising edge, which is one cycle of latency.
- R3: In write-first mode (`WRITE_MODE` = 0), a write cycle without `ssr` puts the newly written `{dinp, din}` on the output.
- R4: In read-first mode (`WRITE_MODE` = 1), a write cycle without `ssr` puts the word that was stored at `addr` before the write on the output.
- R5: In no-change mode (`WRITE_MODE` = 2), a write cycle without `ssr` leaves the output unchanged.
- R6: With `en` and `ssr` high, the output becomes `SRVAL` in every mode. This takes priority over both the read path and the write policy.
- R7: A write with `ssr` high still stores `{dinp, din}` at `addr`.
- R8: During and right after the asynchronous reset, the output equals `INIT_OUT`.
- R9: The side bits are stored per word and returned on `doutp` together with the data bits of the same word.
- R10: After every asynchronous reset, word `i` holds `INIT_IMAGE[i*W +: W]`, with the data in the low bits. This restores any earlier writes to their preloaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all accesses use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously |
| en | input | 1 | Access enable |
| we | input | 1 | Write enable, qualified by `en` |
| ssr | input | 1 | Synchronous set/reset of the output register, qualified by `en` |
| addr | input | $clog2(DEPTH) | Word address |
| din | input | DATA_W | Write data |
| dinp | input | PAR_W | Write side bits |
| dout | output | DATA_W | Registered read data |
| doutp | output | PAR_W | Registered read side bits |

## Verification
The hardest cases are the ones where several controls are set in the same cycle:
- `ssr` and `we` together, where the output must take `SRVAL` while the write must still reach the array.
- `en` low with `we` and `ssr` high, where neither the array nor the output may change.

A change to the array cannot be seen directly at the ports, so the stimulus reads back the same address in the cycle that follows. Three instances, one per write policy, receive identical stimulus. This lets a single sequence of reads and writes show how the three policies differ, with every result matched against one reference memory kept in the bench.

// File: rtl/sram_wmode_pkg.sv
package sram_wmode_pkg;
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;
endpackage

// File: rtl/sram_wmode_rstsync.sv
module sram_wmode_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/sram_wmode_array.sv
module sram_wmode_array #(
  parameter int DATA_W = 16,
  parameter int PAR_W  = 2,
  parameter int DEPTH  = 1024,
  localparam int WORD_W = DATA_W + PAR_W,
  localparam int ADDR_W = $clog2(DEPTH),
  parameter logic [DEPTH*WORD_W-1:0] INIT_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  // preload image: lowest address in the rightmost bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT_IMAGE[i*WORD_W +: WORD_W];
    end else if (wr_en) begin
      mem_q[addr] <= wr_word;
    end
  end

  // contents before this edge's write
  assign rd_word = mem_q[addr];
endmodule

// File: rtl/sram_wmode_outreg.sv
module sram_wmode_outreg
  import sram_wmode_pkg::*;
#(
  parameter int     WORD_W     = 18,
  parameter wmode_e WRITE_MODE = WM_WRITE_FIRST,
  parameter logic [WORD_W-1:0] INIT_OUT = '0,
  parameter logic [WORD_W-1:0] SRVAL    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic              ssr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] out_q
);
  logic [WORD_W-1:0] out_d;
  logic [WORD_W-1:0] wr_pick;

  always_comb begin
    unique case (WRITE_MODE)
      WM_WRITE_FIRST: wr_pick = wr_word;
      WM_READ_FIRST:  wr_pick = rd_word;
      default:        wr_pick = out_q;
    endcase
  end

  always_comb begin
    out_d = out_q;
    if (en) begin
      if (ssr)      out_d = SRVAL;
      else if (we)  out_d = wr_pick;
      else          out_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= INIT_OUT;
    else        out_q <= out_d;
  end
endmodule

// File: rtl/sram_wmode.sv
module sram_wmode
  import sram_wmode_pkg::*;
#(
  parameter int     DATA_W     = 16,
  parameter int     PAR_W      = 2,
  parameter int     DEPTH      = 1024,
  parameter wmode_e WRITE_MODE = WM_WRITE_FIRST,
  localparam int    WORD_W     = DATA_W + PAR_W,
  localparam int    ADDR_W     = $clog2(DEPTH),
  parameter logic [WORD_W-1:0]       INIT_OUT   = '0,
  parameter logic [WORD_W-1:0]       SRVAL      = '0,
  parameter logic [DEPTH*WORD_W-1:0] INIT_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic              ssr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [PAR_W-1:0]  dinp,
  output logic [DATA_W-1:0] dout,
  output logic [PAR_W-1:0]  doutp
);
  logic              rst_q_n;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] out_word;
  logic              wr_en;

  assign wr_word = {dinp, din};
  assign wr_en   = en & we;

  sram_wmode_rstsync #(.STAGES(2)) u_rstsync (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  sram_wmode_array #(
    .DATA_W(DATA_W), .PAR_W(PAR_W), .DEPTH(DEPTH), .INIT_IMAGE(INIT_IMAGE)
  ) u_array (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .addr(addr),
    .wr_word(wr_word), .rd_word(rd_word)
  );

  sram_wmode_outreg #(
    .WORD_W(WORD_W), .WRITE_MODE(WRITE_MODE), .INIT_OUT(INIT_OUT), .SRVAL(SRVAL)
  ) u_outreg (
    .clk(clk), .rst_n(rst_q_n), .en(en), .we(we), .ssr(ssr),
    .wr_word(wr_word), .rd_word(rd_word), .out_q(out_word)
  );

  assign dout  = out_word[DATA_W-1:0];
  assign doutp = out_word[WORD_W-1:DATA_W];
endmodule

// File: rtl/sram_wmode_chk.sv
module sram_wmode_chk
  import sram_wmode_pkg::*;
#(
  parameter int     DATA_W     = 16,
  parameter int     PAR_W      = 2,
  parameter wmode_e WRITE_MODE = WM_WRITE_FIRST,
  localparam int    WORD_W     = DATA_W + PAR_W,
  parameter logic [WORD_W-1:0] SRVAL = '0
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              en,
  input logic              we,
  input logic              ssr,
  input logic [DATA_W-1:0] din,
  input logic [PAR_W-1:0]  dinp,
  input logic [DATA_W-1:0] dout,
  input logic [PAR_W-1:0]  doutp,
  input logic [WORD_W-1:0] rd_word
);
  localparam bit IS_WF = (WRITE_MODE == WM_WRITE_FIRST);
  localparam bit IS_RF = (WRITE_MODE == WM_READ_FIRST);
  localparam bit IS_NC = (WRITE_MODE == WM_NO_CHANGE);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !en |=> ($stable(dout) && $stable(doutp)));

  // R3
  write_first_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (IS_WF && en && we && !ssr) |=> ({doutp, dout} == $past({dinp, din})));

  // R4
  read_first_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (IS_RF && en && we && !ssr) |=> ({doutp, dout} == $past(rd_word)));

  // R5
  no_change_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (IS_NC && en && we && !ssr) |=> ($stable(dout) && $stable(doutp)));

  // R6
  sync_reset_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && ssr) |=> ({doutp, dout} == SRVAL));
endmodule

bind sram_wmode sram_wmode_chk #(
  .DATA_W(DATA_W), .PAR_W(PAR_W), .WRITE_MODE(WRITE_MODE), .SRVAL(SRVAL)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .en(en), .we(we), .ssr(ssr),
  .din(din), .dinp(dinp), .dout(dout), .doutp(doutp), .rd_word(rd_word)
);

// File: tb/sram_wmode_bench.sv
`timescale 1ns/1ps
module sram_wmode_bench;
  import sram_wmode_pkg::*;

  localparam int DW = 8;
  localparam int PW = 1;
  localparam int WW = DW + PW;
  localparam int DEPTH = 16;
  localparam logic [WW-1:0] INIT_OUT = 9'h1A5;
  localparam logic [WW-1:0] SRVAL    = 9'h03C;

  function automatic logic [WW-1:0] seed_word(int i);
    return WW'((i * 37 + 5) & 511);
  endfunction

  function automatic logic [DEPTH*WW-1:0] build_image();
    logic [DEPTH*WW-1:0] img;
    img = '0;
    for (int i = 0; i < DEPTH; i++) img[i*WW +: WW] = seed_word(i);
    return img;
  endfunction

  localparam logic [DEPTH*WW-1:0] IMAGE = build_image();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, we = 1'b0, ssr = 1'b0;
  logic [3:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [PW-1:0] dinp = '0;
  logic [DW-1:0] dout_a [3];
  logic [PW-1:0] doutp_a [3];

  always #2.5 clk = ~clk;

  for (genvar m = 0; m < 3; m++) begin : g_dut
    sram_wmode #(
      .DATA_W(DW), .PAR_W(PW), .DEPTH(DEPTH), .WRITE_MODE(wmode_e'(m)),
      .INIT_OUT(INIT_OUT), .SRVAL(SRVAL), .INIT_IMAGE(IMAGE)
    ) u_sram_wmode (
      .clk(clk), .rst_n(rst_n), .en(en), .we(we), .ssr(ssr), .addr(addr),
      .din(din), .dinp(dinp), .dout(dout_a[m]), .doutp(doutp_a[m])
    );
  end

  typedef struct {
    logic [2:0][WW-1:0] exp;
    string              tag;
  } sb_item_t;

  sb_item_t        sb_q[$];
  logic [WW-1:0]   model [DEPTH];
  logic [WW-1:0]   exp_out [3];
  int              n_tests = 0;
  int              n_fail  = 0;

  task automatic check_word(int m, logic [WW-1:0] act, logic [WW-1:0] exp, string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s mode=%0d actual=%h expected=%h", tag, m, act, exp);
    end
  endtask

  // monitor: pops one expected item per driven cycle
  always @(posedge clk) begin
    #1;
    if (sb_q.size() != 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      for (int m = 0; m < 3; m++) check_word(m, {doutp_a[m], dout_a[m]}, it.exp[m], it.tag);
    end
  end

  // driver: one access per call; expected output per write policy
  task automatic step(bit e, bit w, bit s, int a, logic [WW-1:0] word, string tag);
    sb_item_t it;
    @(negedge clk);
    en = e; we = w; ssr = s; addr = a[3:0]; din = word[DW-1:0]; dinp = word[WW-1:DW];
    for (int m = 0; m < 3; m++) begin
      if (!e)       exp_out[m] = exp_out[m];
      else if (s)   exp_out[m] = SRVAL;
      else if (!w)  exp_out[m] = model[a];
      else if (m == 0) exp_out[m] = word;
      else if (m == 1) exp_out[m] = model[a];
      it.exp[m] = exp_out[m];
    end
    if (e && w) model[a] = word;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic do_reset();
    @(negedge clk);
    en = 1'b0; we = 1'b0; ssr = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) model[i] = seed_word(i);
    for (int m = 0; m < 3; m++) exp_out[m] = INIT_OUT;
    // R8: output at power-up value while reset is held
    for (int m = 0; m < 3; m++) check_word(m, {doutp_a[m], dout_a[m]}, INIT_OUT, "R8 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 3; m++) check_word(m, {doutp_a[m], dout_a[m]}, INIT_OUT, "R8 after release");
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R10 / R2: preload visible through plain reads
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, i, '0, "R10 R2 preload read");
    // R3 R4 R5: writes differ by policy; R9 side bit varies
    step(1, 1, 0, 2, 9'h155, "R3 R4 R5 write");
    step(1, 1, 0, 2, 9'h0AA, "R3 R4 R5 overwrite");
    step(1, 0, 0, 2, '0,     "R9 R2 readback");
    step(1, 1, 0, 7, 9'h1FF, "R3 R4 R5 write");
    step(1, 1, 0, 9, 9'h000, "R3 R4 R5 write");
    step(1, 0, 0, 7, '0,     "R9 readback");
    step(1, 0, 0, 9, '0,     "R9 readback");
    // R1: disabled cycles change nothing
    step(0, 1, 1, 3, 9'h123, "R1 disabled write+ssr");
    step(0, 0, 0, 5, '0,     "R1 disabled read");
    step(1, 0, 0, 3, '0,     "R1 memory untouched");
    // R6 / R7
    step(1, 0, 1, 4, '0,     "R6 ssr read");
    step(1, 0, 0, 4, '0,     "R2 read after ssr");
    step(1, 1, 1, 4, 9'h1C3, "R6 R7 ssr write");
    step(1, 0, 0, 4, '0,     "R7 write during ssr stored");
    step(1, 1, 0, 4, 9'h0F0, "R5 no-change after read");
    // R10: reset restores preload image
    repeat (2) @(negedge clk);
    do_reset();
    step(1, 0, 0, 2, '0, "R10 restore");
    step(1, 0, 0, 4, '0, "R10 restore");
    step(1, 0, 0, 7, '0, "R10 restore");
    step(1, 0, 0, 9, '0, "R10 restore");
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule